// File: doc/BRIEF.md
# Microscaling Multiply-Accumulate Coprocessor

This block sits beside a scalar core and runs a small set of custom register-register instructions. The core presents the instruction word and the two source operand values with a valid/ready handshake. The block picks out its operations from the major opcode and the funct3 field, and it answers with a response strobe and a result value for the destination register. It holds a configuration register, two shared block scales and a 32-bit signed accumulator. The accumulator is a fixed-point number with 8 fractional bits.

A multiply-accumulate step receives four A elements and four B elements, packed one per byte lane of the two operands. The configured format can be one of five small floating-point encodings or one of two 8-bit integer encodings. Each pair is decoded, multiplied and scaled by the two shared power-of-two scales, then rounded into the accumulator's fixed-point grid. The four terms are added to the accumulator. The result then either saturates to the signed 32-bit range or wraps modulo 2^32. The datapath handles one lane pair per clock, so a step holds the core off for several cycles.

Top module: `mx_mac_copro`

## Requirements
- R1: After reset is released, `req_ready` is high while the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Every operation other than a MAC step raises `resp_valid` in the cycle straight after the accepting edge. `resp_valid` is never high together with `req_ready` low.
- R2: A MAC step (opcode 0x0b, funct3 2) keeps `req_ready` low while it runs. It raises `resp_valid` 5 clock edges after the accepting edge, which is one edge per lane plus one.
- R3: Set-format (opcode 0x0b, funct3 0) loads the configuration from rs1. Bits [2:0] hold the format ID and bits [4:3] the rounding mode. Bit 5 selects wrap (1) or saturate (0). When bit 6 is 1, the accumulator is also cleared to zero.
- R4: Load-scale (opcode 0x0b, funct3 1) loads the A scale from rs1[7:0] and the B scale from rs2[7:0]. Each scale is an unsigned power-of-two exponent with bias 127. Reset leaves both scales at 127, which means ×1.
- R5: Element i of A sits in rs1[8i+7:8i] and element i of B sits in rs2[8i+7:8i]. The narrow formats use the low bits of each lane. The sign is the top bit used, followed by the exponent field and then the mantissa field. The format IDs and their exponent bits / mantissa bits / bias are: 0 = 4/3/7, 1 = 5/2/15, 2 = 3/2/3, 3 = 2/3/1, 4 = 2/1/1. An exponent field of zero gives a subnormal value: no hidden one, and the exponent is taken as 1. All other codes decode as finite numbers.
- R6: ID 5 is signed 8-bit two's complement. ID 6 is the same, except that −128 is taken as −127. ID 7 behaves like ID 5.
- R7: Each product is multiplied by 2^(sA−127+sB−127+8) and rounded to an integer with the configured mode. The modes are 0 round to nearest with ties to even, 1 toward zero, 2 toward +∞ and 3 toward −∞.
- R8: The magnitude of each rounded term is capped at 2^32. The four terms are added to the accumulator in wide arithmetic. The sum then either saturates to [−2^31, 2^31−1] or keeps its low 32 bits.
- R9: Read (opcode 0x0b, funct3 3) returns the accumulator on `resp_rd` and leaves it unchanged. All other operations return 0.
- R10: A request with a different opcode, or with funct3 above 3, is accepted and answered with 0. It changes no state.
- R11: Reset leaves the format ID at 0, the rounding mode at 0, saturation selected and the accumulator at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core presents an instruction |
| req_ready | output | 1 | Block can accept an instruction |
| req_instr | input | 32 | Instruction word |
| req_rs1 | input | 32 | First source operand value |
| req_rs2 | input | 32 | Second source operand value |
| resp_valid | output | 1 | Result strobe, one cycle |
| resp_rd | output | 32 | Destination register value |

## Verification
The properties assume that the core sends requests only as the handshake allows. They also assume that the instruction word and operands are stable in the cycle of acceptance. They do not assume that the core waits for a response before it raises `req_valid` again. The stimulus is stricter than that. It sends one request at a time, waits for `resp_valid` before the next one, and drives all inputs on the falling edge. The random part spreads the scales around 127, with occasional extreme values. It mixes all eight format IDs, the four rounding modes and both overflow behaviours, so that rounding, subnormals, clamping and wrapping all come up.

// File: rtl/mx_mac_pkg.sv
package mx_mac_pkg;

  typedef enum logic [2:0] {
    FMT_E4M3  = 3'd0,
    FMT_E5M2  = 3'd1,
    FMT_E3M2  = 3'd2,
    FMT_E2M3  = 3'd3,
    FMT_E2M1  = 3'd4,
    FMT_INT8  = 3'd5,
    FMT_INT8S = 3'd6,
    FMT_RSVD  = 3'd7
  } mx_fmt_e;

  typedef enum logic [1:0] {
    RND_NEAR_EVEN = 2'd0,
    RND_ZERO      = 2'd1,
    RND_UP        = 2'd2,
    RND_DOWN      = 2'd3
  } mx_rnd_e;

  typedef struct packed {
    mx_fmt_e fmt;
    mx_rnd_e rnd;
    logic    wrap;
  } mx_cfg_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } mx_state_e;

  localparam logic [6:0] OPC_MX   = 7'h0b;
  localparam logic [2:0] OP_SETUP = 3'd0;
  localparam logic [2:0] OP_SCALE = 3'd1;
  localparam logic [2:0] OP_STEP  = 3'd2;
  localparam logic [2:0] OP_READ  = 3'd3;

  localparam int SCALE_BIAS = 127;

endpackage

// File: rtl/mx_elem_decode.sv
module mx_elem_decode
  import mx_mac_pkg::*;
(
  input  mx_fmt_e            fmt,
  input  logic [7:0]         code,
  output logic               neg,
  output logic [7:0]         mag,
  output logic signed [6:0]  expo
);

  logic [4:0] efield;
  logic [3:0] mfield;
  int         mbits;
  int         bias;
  logic       is_fp;

  always_comb begin
    efield = '0;
    mfield = '0;
    mbits  = 0;
    bias   = 0;
    is_fp  = 1'b1;
    neg    = code[7];
    unique case (fmt)
      FMT_E4M3: begin efield = {1'b0, code[6:3]}; mfield = {1'b0, code[2:0]}; mbits = 3; bias = 7;  end
      FMT_E5M2: begin efield = code[6:2];          mfield = {2'b0, code[1:0]}; mbits = 2; bias = 15; end
      FMT_E3M2: begin neg = code[5]; efield = {2'b0, code[4:2]}; mfield = {2'b0, code[1:0]}; mbits = 2; bias = 3; end
      FMT_E2M3: begin neg = code[5]; efield = {3'b0, code[4:3]}; mfield = {1'b0, code[2:0]}; mbits = 3; bias = 1; end
      FMT_E2M1: begin neg = code[3]; efield = {3'b0, code[2:1]}; mfield = {3'b0, code[0]};   mbits = 1; bias = 1; end
      default:  is_fp = 1'b0;
    endcase

    if (is_fp) begin
      if (efield == '0) begin
        mag  = {4'b0, mfield};
        expo = 7'(1 - bias - mbits);
      end else begin
        mag  = {4'b0, mfield} | (8'd1 << mbits);
        expo = 7'(int'(efield) - bias - mbits);
      end
    end else begin
      expo = '0;
      mag  = code[7] ? 8'(-code) : code;
      if (fmt == FMT_INT8S && code == 8'h80) mag = 8'd127;
    end
  end

endmodule

// File: rtl/mx_term_conv.sv
module mx_term_conv
  import mx_mac_pkg::*;
#(
  parameter int FRAC   = 8,
  parameter int ACC_W  = 32,
  localparam int TERM_W = ACC_W + 2,
  localparam int MAX_L  = ACC_W + 1,
  localparam int MAX_R  = 31
) (
  input  logic               neg_a,
  input  logic [7:0]         mag_a,
  input  logic signed [6:0]  exp_a,
  input  logic               neg_b,
  input  logic [7:0]         mag_b,
  input  logic signed [6:0]  exp_b,
  input  logic [7:0]         scale_a,
  input  logic [7:0]         scale_b,
  input  mx_rnd_e            rnd,
  output logic signed [TERM_W-1:0] term
);

  localparam logic [63:0] CAP = 64'd1 << ACC_W;

  logic [15:0] prod;
  logic        neg;
  int          shamt;
  int          sr;
  logic [63:0] wide;
  logic [63:0] quo;
  logic [63:0] rem;
  logic [63:0] half;
  logic        bump;
  logic [ACC_W:0] res_mag;

  always_comb begin
    prod  = 16'(mag_a) * 16'(mag_b);
    neg   = neg_a ^ neg_b;
    shamt = int'(exp_a) + int'(exp_b) + int'(scale_a) + int'(scale_b)
          - 2 * SCALE_BIAS + FRAC;
    wide  = '0;
    quo   = '0;
    rem   = '0;
    half  = '0;
    bump  = 1'b0;
    sr    = 0;
    if (shamt >= 0) begin
      wide    = 64'(prod) << ((shamt > MAX_L) ? MAX_L : shamt);
      res_mag = (wide > CAP) ? CAP[ACC_W:0] : wide[ACC_W:0];
    end else begin
      sr   = (-shamt > MAX_R) ? MAX_R : -shamt;
      quo  = 64'(prod) >> sr;
      rem  = 64'(prod) & ((64'd1 << sr) - 64'd1);
      half = 64'd1 << (sr - 1);
      unique case (rnd)
        RND_NEAR_EVEN: bump = (rem > half) || ((rem == half) && quo[0]);
        RND_ZERO:      bump = 1'b0;
        RND_UP:        bump = !neg && (rem != '0);
        default:       bump = neg && (rem != '0);
      endcase
      res_mag = quo[ACC_W:0] + (ACC_W+1)'(bump);
    end
    term = neg ? -$signed({1'b0, res_mag}) : $signed({1'b0, res_mag});
  end

endmodule

// File: rtl/mx_mac_copro.sv
module mx_mac_copro
  import mx_mac_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int ELEM_W = 8,
  parameter int ACC_W  = 32,
  parameter int FRAC   = 8,
  localparam int XLEN   = LANES * ELEM_W,
  localparam int LIDX_W = $clog2(LANES),
  localparam int TERM_W = ACC_W + 2,
  localparam int SUM_W  = ACC_W + LIDX_W + 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [31:0]     req_instr,
  input  logic [XLEN-1:0] req_rs1,
  input  logic [XLEN-1:0] req_rs2,
  output logic            resp_valid,
  output logic [ACC_W-1:0] resp_rd
);

  localparam logic signed [SUM_W-1:0] ACC_MAX = {{(SUM_W-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] ACC_MIN = {{(SUM_W-ACC_W+1){1'b1}}, {(ACC_W-1){1'b0}}};

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  mx_state_e                state_q, state_d;
  logic [LIDX_W-1:0]        lane_q, lane_d;
  mx_cfg_t                  cfg_q, cfg_d;
  logic [7:0]               sca_q, sca_d, scb_q, scb_d;
  logic signed [ACC_W-1:0]  acc_q, acc_d;
  logic signed [SUM_W-1:0]  sum_q, sum_d;
  logic [XLEN-1:0]          opa_q, opa_d, opb_q, opb_d;
  logic                     resp_valid_q, resp_valid_d;
  logic [ACC_W-1:0]         resp_rd_q, resp_rd_d;
  logic cfg_en, sc_en, acc_en, op_en;

  logic       accept, ours;
  logic [2:0] f3;
  logic       unused_instr;
  assign f3           = req_instr[14:12];
  assign ours         = req_instr[6:0] == OPC_MX;
  assign accept       = req_valid && req_ready;
  assign unused_instr = ^{req_instr[31:15], req_instr[11:7]};

  // lane-serial datapath
  logic [ELEM_W-1:0] lane_a [LANES];
  logic [ELEM_W-1:0] lane_b [LANES];
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_a[g] = opa_q[g*ELEM_W +: ELEM_W];
    assign lane_b[g] = opb_q[g*ELEM_W +: ELEM_W];
  end

  logic              na, nb;
  logic [7:0]        ma, mb;
  logic signed [6:0] ea, eb;
  logic signed [TERM_W-1:0] term;
  logic signed [SUM_W-1:0]  sum_next;
  logic signed [ACC_W-1:0]  acc_final;

  mx_elem_decode u_dec_a (.fmt(cfg_q.fmt), .code(lane_a[lane_q]), .neg(na), .mag(ma), .expo(ea));
  mx_elem_decode u_dec_b (.fmt(cfg_q.fmt), .code(lane_b[lane_q]), .neg(nb), .mag(mb), .expo(eb));

  mx_term_conv #(.FRAC(FRAC), .ACC_W(ACC_W)) u_term (
    .neg_a(na), .mag_a(ma), .exp_a(ea),
    .neg_b(nb), .mag_b(mb), .exp_b(eb),
    .scale_a(sca_q), .scale_b(scb_q), .rnd(cfg_q.rnd), .term(term)
  );

  always_comb begin
    sum_next = sum_q + SUM_W'(term);
    if (cfg_q.wrap)              acc_final = sum_next[ACC_W-1:0];
    else if (sum_next > ACC_MAX) acc_final = ACC_MAX[ACC_W-1:0];
    else if (sum_next < ACC_MIN) acc_final = ACC_MIN[ACC_W-1:0];
    else                         acc_final = sum_next[ACC_W-1:0];
  end

  assign req_ready = (state_q == ST_IDLE) && rst_sync_n;

  // next state
  always_comb begin
    state_d = state_q;  lane_d = lane_q;
    cfg_d = cfg_q;      sca_d = sca_q;  scb_d = scb_q;
    acc_d = acc_q;      sum_d = sum_q;
    opa_d = opa_q;      opb_d = opb_q;
    resp_valid_d = 1'b0;
    resp_rd_d    = resp_rd_q;
    cfg_en = 1'b0; sc_en = 1'b0; acc_en = 1'b0; op_en = 1'b0;
    if (state_q == ST_IDLE) begin
      if (accept) begin
        resp_valid_d = 1'b1;
        resp_rd_d    = '0;
        if (ours) begin
          unique case (f3)
            OP_SETUP: begin
              cfg_en = 1'b1;
              cfg_d  = '{fmt: mx_fmt_e'(req_rs1[2:0]), rnd: mx_rnd_e'(req_rs1[4:3]), wrap: req_rs1[5]};
              if (req_rs1[6]) begin acc_en = 1'b1; acc_d = '0; end
            end
            OP_SCALE: begin
              sc_en = 1'b1; sca_d = req_rs1[7:0]; scb_d = req_rs2[7:0];
            end
            OP_STEP: begin
              op_en = 1'b1; opa_d = req_rs1; opb_d = req_rs2;
              sum_d = SUM_W'(acc_q);
              lane_d = '0;
              state_d = ST_BUSY;
              resp_valid_d = 1'b0;
            end
            OP_READ: resp_rd_d = acc_q;
            default: ;
          endcase
        end
      end
    end else begin
      sum_d  = sum_next;
      lane_d = lane_q + 1'b1;
      if (lane_q == LIDX_W'(LANES-1)) begin
        acc_en = 1'b1; acc_d = acc_final;
        state_d = ST_IDLE;
        resp_valid_d = 1'b1;
        resp_rd_d = '0;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;  lane_q <= '0;
      cfg_q   <= '{fmt: FMT_E4M3, rnd: RND_NEAR_EVEN, wrap: 1'b0};
      sca_q   <= 8'(SCALE_BIAS); scb_q <= 8'(SCALE_BIAS);
      acc_q   <= '0;  sum_q <= '0;
      opa_q   <= '0;  opb_q <= '0;
      resp_valid_q <= 1'b0; resp_rd_q <= '0;
    end else begin
      state_q <= state_d;
      lane_q  <= lane_d;
      sum_q   <= sum_d;
      resp_valid_q <= resp_valid_d;
      resp_rd_q    <= resp_rd_d;
      if (cfg_en) cfg_q <= cfg_d;
      if (sc_en)  begin sca_q <= sca_d; scb_q <= scb_d; end
      if (acc_en) acc_q <= acc_d;
      if (op_en)  begin opa_q <= opa_d; opb_q <= opb_d; end
    end
  end

  assign resp_valid = resp_valid_q;
  assign resp_rd    = resp_rd_q;

endmodule

// File: rtl/mx_mac_copro_chk.sv
module mx_mac_copro_chk #(
  parameter int ACC_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [31:0]      req_instr,
  input logic             resp_valid,
  input logic [ACC_W-1:0] resp_rd,
  input logic [ACC_W-1:0] acc
);

  logic acc_ok, ours, is_step, is_read;
  assign acc_ok  = req_valid && req_ready;
  assign ours    = req_instr[6:0] == 7'h0b;
  assign is_step = ours && req_instr[14:12] == 3'd2;
  assign is_read = ours && req_instr[14:12] == 3'd3;

  // R1: non-step operations answer on the next cycle
  a_r1_quick_resp: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok && !is_step |=> resp_valid);

  // R1: a response never appears while the block is busy
  a_r1_resp_idle: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> req_ready);

  // R2: a step stalls the core, then answers after five edges
  a_r2_step_stall: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok && is_step |=> !req_ready);
  a_r2_step_latency: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok && is_step |-> ##5 resp_valid);

  // R9: read returns and keeps the accumulator
  a_r9_read_value: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok && is_read |=> resp_rd == $past(acc));
  a_r9_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok && is_read |=> $stable(acc));

  // R10: foreign opcodes leave the accumulator alone
  a_r10_foreign_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok && !ours |=> $stable(acc));

endmodule

bind mx_mac_copro mx_mac_copro_chk #(.ACC_W(ACC_W)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_instr(req_instr), .resp_valid(resp_valid), .resp_rd(resp_rd), .acc(acc_q)
);

// File: tb/mx_mac_copro_tb.sv
`timescale 1ns/1ps
module mx_mac_copro_tb_top;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_instr;
  logic [31:0] req_rs1;
  logic [31:0] req_rs2;
  logic        resp_valid;
  logic [31:0] resp_rd;

  mx_mac_copro dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_instr(req_instr), .req_rs1(req_rs1), .req_rs2(req_rs2),
    .resp_valid(resp_valid), .resp_rd(resp_rd)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  // reference state
  int     m_fmt, m_rnd, m_wrap, m_sa, m_sb;
  longint m_acc;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void dec(input int fmt, input int code, output longint sig, output int ex);
    int eb, mb, bias, s, e, m;
    longint mant;
    eb = 0; mb = 0; bias = 0;
    case (fmt)
      0: begin eb = 4; mb = 3; bias = 7;  end
      1: begin eb = 5; mb = 2; bias = 15; end
      2: begin eb = 3; mb = 2; bias = 3;  end
      3: begin eb = 2; mb = 3; bias = 1;  end
      4: begin eb = 2; mb = 1; bias = 1;  end
      default: eb = 0;
    endcase
    if (eb != 0) begin
      s = (code >> (eb + mb)) & 1;
      e = (code >> mb) & ((1 << eb) - 1);
      m = code & ((1 << mb) - 1);
      if (e == 0) begin mant = m; ex = 1 - bias - mb; end
      else begin mant = m + (1 << mb); ex = e - bias - mb; end
      sig = s ? -mant : mant;
    end else begin
      sig = (code >= 128) ? code - 256 : code;
      if (fmt == 6 && sig == -128) sig = -127;
      ex = 0;
    end
  endfunction

  function automatic longint conv(input longint p, input int k, input int rnd);
    bit neg;
    longint m, q, r, h, res;
    neg = p < 0;
    m = neg ? -p : p;
    if (k >= 0) begin
      res = m << ((k > 40) ? 40 : k);
      if (res > (64'sd1 <<< 32)) res = 64'sd1 <<< 32;
    end else if (-k > 40) begin
      res = ((rnd == 2 && !neg && m != 0) || (rnd == 3 && neg && m != 0)) ? 1 : 0;
    end else begin
      q = m >> (-k);
      r = m - (q << (-k));
      h = 64'sd1 <<< (-k - 1);
      res = q;
      if (rnd == 0 && (r > h || (r == h && q[0]))) res = q + 1;
      if (rnd == 2 && !neg && r != 0) res = q + 1;
      if (rnd == 3 && neg && r != 0) res = q + 1;
    end
    return neg ? -res : res;
  endfunction

  task automatic issue(input logic [6:0] opc, input logic [2:0] f3, input logic [31:0] a,
                       input logic [31:0] b, input int exp_lat, input string req,
                       output logic [31:0] rd);
    int lat;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_instr = {7'd0, 5'd2, 5'd1, f3, 5'd3, opc};
    req_rs1 = a; req_rs2 = b;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!resp_valid && lat < 40) begin @(negedge clk); lat++; end
    check(lat == exp_lat, req, "response latency", lat, exp_lat);
    rd = resp_rd;
  endtask

  task automatic do_setfmt(input logic [31:0] v);
    logic [31:0] rd;
    issue(7'h0b, 3'd0, v, 32'h0, 1, "R3", rd);
    check(rd == 0, "R9", "setfmt rd", rd, 0);
    m_fmt = v[2:0]; m_rnd = v[4:3]; m_wrap = v[5];
    if (v[6]) m_acc = 0;
  endtask

  task automatic do_scale(input int sa, input int sb);
    logic [31:0] rd;
    issue(7'h0b, 3'd1, 32'(sa), 32'(sb), 1, "R4", rd);
    check(rd == 0, "R9", "scale rd", rd, 0);
    m_sa = sa; m_sb = sb;
  endtask

  task automatic do_step(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] rd;
    longint sum, sa_v, sb_v;
    int ea, eb;
    sum = m_acc;
    for (int i = 0; i < 4; i++) begin
      dec(m_fmt, int'(a[8*i +: 8]), sa_v, ea);
      dec(m_fmt, int'(b[8*i +: 8]), sb_v, eb);
      sum += conv(sa_v * sb_v, ea + eb + (m_sa - 127) + (m_sb - 127) + 8, m_rnd);
    end
    if (m_wrap) m_acc = longint'(int'(sum));
    else if (sum > 64'sd2147483647) m_acc = 64'sd2147483647;
    else if (sum < -64'sd2147483648) m_acc = -64'sd2147483648;
    else m_acc = sum;
    issue(7'h0b, 3'd2, a, b, 5, "R2", rd);
    check(rd == 0, "R9", "step rd", rd, 0);
  endtask

  task automatic do_read(input string req);
    logic [31:0] rd;
    issue(7'h0b, 3'd3, 32'h0, 32'h0, 1, "R1", rd);
    check(longint'($signed(rd)) == m_acc, req, "accumulator", longint'($signed(rd)), m_acc);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd20240611));
    req_valid = 0; req_instr = 0; req_rs1 = 0; req_rs2 = 0;
    m_fmt = 0; m_rnd = 0; m_wrap = 0; m_sa = 127; m_sb = 127; m_acc = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check(req_ready == 0 && resp_valid == 0, "R11", "outputs in reset", resp_valid, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(req_ready == 1, "R1", "ready after reset", req_ready, 1);
    check(resp_valid == 0, "R11", "no response after reset", resp_valid, 0);
    do_read("R11");

    // R5: default format, 1.0 * 1.0 in every lane -> 4 * 256
    do_step(32'h38383838, 32'h38383838);
    check(m_acc == 1024, "R5", "model e4m3 one", m_acc, 1024);
    do_read("R5");
    do_read("R9");                       // R9: reading twice keeps the value
    // R5: subnormals and each fp format
    for (int f = 0; f < 5; f++) begin
      do_setfmt(32'(f) | 32'h40);
      do_step(32'h01_07_3C_A5, 32'h02_81_1F_33);
      do_read("R5");
    end
    // R6: integer formats and the symmetric clamp
    do_setfmt(32'h45);
    do_step(32'h80_7F_FD_02, 32'h80_01_07_05);
    do_read("R6");
    do_setfmt(32'h46);
    do_step(32'h80_7F_FD_02, 32'h80_01_07_05);
    do_read("R6");
    do_setfmt(32'h47);
    do_step(32'h80_00_00_80, 32'h80_00_00_01);
    do_read("R6");
    // R7: each rounding mode on ties and fractions, both signs
    do_scale(127 - 12, 127);
    for (int r = 0; r < 4; r++) begin
      do_setfmt(32'h45 | (32'(r) << 3));
      do_step(32'h18_E8_03_FD, 32'h01_01_07_01);
      do_read("R7");
      do_step(32'h28_D8_0B_F5, 32'h01_01_01_01);
      do_read("R7");
    end
    // R8: saturation and wrap
    do_scale(131, 131);
    do_setfmt(32'h45);
    do_step(32'h7F7F7F7F, 32'h7F7F7F7F);
    check(m_acc == 64'sd2147483647, "R8", "model saturates", m_acc, 64'sd2147483647);
    do_read("R8");
    do_setfmt(32'h45);
    do_step(32'h80808080, 32'h7F7F7F7F);
    do_read("R8");
    do_setfmt(32'h65);
    do_step(32'h7F7F7F7F, 32'h7F7F7F7F);
    do_read("R8");
    do_scale(200, 200);
    do_step(32'h00000001, 32'h00000001);   // term capped at 2^32
    do_read("R8");
    // R3: set-format without clear keeps the accumulator
    do_setfmt(32'h05);
    do_read("R3");
    // R10: foreign opcode and unused funct3 change nothing
    issue(7'h33, 3'd2, 32'h7F7F7F7F, 32'h7F7F7F7F, 1, "R10", rd);
    check(rd == 0, "R10", "foreign rd", rd, 0);
    do_read("R10");
    issue(7'h0b, 3'd5, 32'h00000040, 32'h0, 1, "R10", rd);
    check(rd == 0, "R10", "funct3 5 rd", rd, 0);
    do_read("R10");
    // R4: scales reloaded
    do_scale(127, 127);
    do_setfmt(32'h40);
    do_step(32'h38383838, 32'h38383838);
    do_read("R4");

    // random mix
    for (int it = 0; it < 500; it++) begin
      int sel;
      sel = $urandom % 10;
      if (sel == 0) do_setfmt(($urandom % 64) | ((($urandom % 4) == 0) ? 32'h40 : 32'h0));
      else if (sel == 1) begin
        if (($urandom % 8) == 0) do_scale($urandom % 256, $urandom % 256);
        else do_scale(107 + ($urandom % 41), 107 + ($urandom % 41));
      end
      else if (sel < 7) do_step($urandom, $urandom);
      else do_read("R8");
    end
    do_read("R7");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule